// File: doc/BRIEF.md
# Cycle-Window Response Checker

This block is a clocked hardware monitor. It watches a W-bit tracked value and, each time a trigger is sampled high, opens a checking window that spans a configured range of clock edges counted from that trigger. Within the window the value is held against one of four properties: it always matches an expected value, it moves from some other value to the expected one, it changes at all, or it holds still. Each window ends with a single-cycle pass pulse or a single-cycle fail pulse on the bit that belongs to the tracker that owns it.

Up to P windows can be open at the same time. Each has its own cycle counter and saved state, so a trigger that arrives while earlier windows are still open starts a new, independent window. A window that passes is retired as soon as its pass is certain. Stable mode and value mode must observe their whole range before they can pass. The configuration (mode, bounds, expected value) is captured when the enable input rises and stays frozen while enable stays high. Dropping enable discards every open window.

Top module: `win_resp_mon`

## Requirements
- R1: While reset is high and after it is released, `alert_pipe`, `ack_pipe` and `overflow` are all zero, and no window is open.
- R2: The edge at which trigger is sampled high is cycle 0 of a window. The window covers the cycles from `min_cyc` to `max_cyc`, both included, so `min_cyc = max_cyc = 0` checks only the trigger edge. The outcome decided at an edge is shown as a one-cycle pulse in the clock cycle that follows that edge, and only for a pipe that was open or starting at that edge.
- R3: Mode 0 (value): a mismatch against the expected value at any in-window edge fails at once. If every in-window edge matches, the window passes at edge `max_cyc`.
- R4: Mode 1 (change to value): the window passes at the first in-window edge where the value equals the expected value, provided a differing value was seen at an earlier in-window edge. If that has not happened by edge `max_cyc`, the window fails there.
- R5: Mode 2 (change): the value at the first in-window edge becomes the reference, and a change before that does not count. The window passes at the first later in-window edge whose value differs from the reference, and fails at `max_cyc` otherwise. With `min_cyc = max_cyc` it always fails.
- R6: Mode 3 (stable): the first in-window value is the reference. Any differing in-window value fails at once. The pass pulse comes only at edge `max_cyc`, and a 0-to-0 window always passes.
- R7: A retired tracker is free for a new trigger at the next edge.
- R8: A trigger takes the lowest-numbered free tracker. Bit i of `alert_pipe` and of `ack_pipe` reports tracker i, and windows that overlap are judged independently.
- R9: A trigger that arrives while all P trackers are busy is not tracked, and `overflow` pulses for one cycle after that edge.
- R10: An edge with enable low closes every window and clears their state, so no pulse results from windows that were open before. The configuration inputs are captured at the edge where enable rises, and later changes are ignored until enable drops.
- R11: A tracker never reports pass and fail in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Monitor enable; the rising edge latches configuration |
| trig | input | 1 | Opens a window at this edge (cycle 0) |
| trk | input | W | Tracked value |
| exp_val | input | W | Expected value (modes 0 and 1) |
| min_cyc | input | CW | First in-window cycle, inclusive |
| max_cyc | input | CW | Last in-window cycle, inclusive |
| mode | input | 2 | 0 value, 1 change to value, 2 change, 3 stable |
| alert_pipe | output | P | One-cycle fail pulse per tracker |
| ack_pipe | output | P | One-cycle pass pulse per tracker |
| overflow | output | 1 | One-cycle pulse: trigger dropped, all trackers busy |

## Verification
A tracker whose counter drifts moves the pass or fail pulse by one or more cycles. The bench therefore records the exact cycle of the first pulse for every stimulus vector, not only which kind of pulse it was. A reference or "seen different" flag left over from an earlier window turns a fail into a pass, or a pass into a fail, within that same window. Wrong allocation or a wrong free state shows up on the first overlapping trigger, either as a pulse on the wrong bit or as a missing or false `overflow`.

// File: rtl/win_mon_pkg.sv
package win_mon_pkg;
  typedef enum logic [1:0] {
    MODE_VALUE  = 2'd0,
    MODE_CHG_TO = 2'd1,
    MODE_CHANGE = 2'd2,
    MODE_STABLE = 2'd3
  } win_mode_e;
endpackage

// File: rtl/win_alloc.sv
module win_alloc #(
  parameter int P = 4
) (
  input  logic [P-1:0] busy,
  input  logic         req,
  output logic [P-1:0] grant,
  output logic         full
);
  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < P; i++) begin
      if (!busy[i] && !found) begin
        grant[i] = req;
        found    = 1'b1;
      end
    end
    full = &busy;
  end
endmodule

// File: rtl/win_slot.sv
module win_slot
  import win_mon_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start,
  input  logic [W-1:0]  trk,
  input  logic [W-1:0]  exp_val,
  input  logic [CW-1:0] min_c,
  input  logic [CW-1:0] max_c,
  input  win_mode_e     mode,
  output logic          busy,
  output logic          pass,
  output logic          fail
);
  logic          busy_q, ref_ok_q, diff_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  ref_q;

  logic          act, inwin, last, eq_exp, eq_ref, have_ref;
  logic [CW-1:0] cyc;

  always_comb begin
    act      = en & (busy_q | start);
    cyc      = busy_q ? cnt_q : '0;
    inwin    = act && (cyc >= min_c) && (cyc <= max_c);
    last     = act && (cyc >= max_c);
    eq_exp   = (trk == exp_val);
    eq_ref   = (trk == ref_q);
    have_ref = busy_q & ref_ok_q;
    pass     = 1'b0;
    fail     = 1'b0;
    unique case (mode)
      MODE_VALUE: begin
        fail = inwin && !eq_exp;
        pass = last && !fail;
      end
      MODE_CHG_TO: begin
        pass = inwin && busy_q && diff_q && eq_exp;
        fail = last && !pass;
      end
      MODE_CHANGE: begin
        pass = inwin && have_ref && !eq_ref;
        fail = last && !pass;
      end
      MODE_STABLE: begin
        fail = inwin && have_ref && !eq_ref;
        pass = last && !fail;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy_q   <= 1'b0;
      ref_ok_q <= 1'b0;
      diff_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (act) begin
      if (pass || fail) begin
        busy_q   <= 1'b0;
        ref_ok_q <= 1'b0;
        diff_q   <= 1'b0;
      end else begin
        busy_q <= 1'b1;
        cnt_q  <= cyc + CW'(1);
        if (inwin) ref_ok_q <= 1'b1;
        if (inwin && !eq_exp) diff_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (act && inwin && !have_ref) ref_q <= trk;
  end

  assign busy = busy_q;
endmodule

// File: rtl/win_resp_mon.sv
module win_resp_mon
  import win_mon_pkg::*;
#(
  parameter int W  = 8,
  parameter int P  = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          trig,
  input  logic [W-1:0]  trk,
  input  logic [W-1:0]  exp_val,
  input  logic [CW-1:0] min_cyc,
  input  logic [CW-1:0] max_cyc,
  input  logic [1:0]    mode,
  output logic [P-1:0]  alert_pipe,
  output logic [P-1:0]  ack_pipe,
  output logic          overflow
);
  logic          en_q;
  logic [W-1:0]  cfg_exp_q, eff_exp;
  logic [CW-1:0] cfg_min_q, cfg_max_q, eff_min, eff_max;
  win_mode_e     cfg_mode_q, eff_mode;

  logic [P-1:0]  busy_vec, start_vec, pass_vec, fail_vec;
  logic          all_busy, take;

  // configuration: live while disabled, frozen from the enable-rise edge on
  always_comb begin
    eff_exp  = en_q ? cfg_exp_q  : exp_val;
    eff_min  = en_q ? cfg_min_q  : min_cyc;
    eff_max  = en_q ? cfg_max_q  : max_cyc;
    eff_mode = en_q ? cfg_mode_q : win_mode_e'(mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      cfg_exp_q  <= '0;
      cfg_min_q  <= '0;
      cfg_max_q  <= '0;
      cfg_mode_q <= MODE_VALUE;
    end else begin
      en_q <= en;
      if (en) begin
        cfg_exp_q  <= eff_exp;
        cfg_min_q  <= eff_min;
        cfg_max_q  <= eff_max;
        cfg_mode_q <= eff_mode;
      end
    end
  end

  assign take = en & trig;

  win_alloc #(.P(P)) i_alloc (
    .busy  (busy_vec),
    .req   (take),
    .grant (start_vec),
    .full  (all_busy)
  );

  for (genvar g = 0; g < P; g++) begin : g_slot
    win_slot #(.W(W), .CW(CW)) i_slot (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .start   (start_vec[g]),
      .trk     (trk),
      .exp_val (eff_exp),
      .min_c   (eff_min),
      .max_c   (eff_max),
      .mode    (eff_mode),
      .busy    (busy_vec[g]),
      .pass    (pass_vec[g]),
      .fail    (fail_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      alert_pipe <= '0;
      ack_pipe   <= '0;
      overflow   <= 1'b0;
    end else begin
      alert_pipe <= fail_vec;
      ack_pipe   <= pass_vec;
      overflow   <= take & all_busy;
    end
  end
endmodule

// File: rtl/win_resp_mon_chk.sv
module win_resp_mon_chk #(
  parameter int P  = 4,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          en_q,
  input logic          trig,
  input logic [P-1:0]  alert_pipe,
  input logic [P-1:0]  ack_pipe,
  input logic          overflow,
  input logic [P-1:0]  busy_vec,
  input logic [P-1:0]  start_vec,
  input logic [CW-1:0] cfg_min_q,
  input logic [CW-1:0] cfg_max_q
);
  a_r11_no_dual_report: assert property (@(posedge clk) disable iff (rst)
    (alert_pipe & ack_pipe) == '0);

  a_r9_overflow_cause: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(trig && en && (&busy_vec)));

  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (alert_pipe == '0 && ack_pipe == '0 && !overflow));

  a_r2_report_from_live: assert property (@(posedge clk) disable iff (rst)
    ((alert_pipe | ack_pipe) & ~$past(busy_vec | start_vec)) == '0);

  a_r8_grant_free_one: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_vec) && ((start_vec & busy_vec) == '0));

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (en && en_q) |=> ($stable(cfg_min_q) && $stable(cfg_max_q)));
endmodule

bind win_resp_mon win_resp_mon_chk #(.P(P), .CW(CW)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .en_q       (en_q),
  .trig       (trig),
  .alert_pipe (alert_pipe),
  .ack_pipe   (ack_pipe),
  .overflow   (overflow),
  .busy_vec   (busy_vec),
  .start_vec  (start_vec),
  .cfg_min_q  (cfg_min_q),
  .cfg_max_q  (cfg_max_q)
);

// File: tb/test_win_resp_mon.sv
module test_win_resp_mon;
  localparam int W = 8, P = 4, CW = 8;

  logic          clk = 1'b0, rst = 1'b1, en = 1'b0, trig = 1'b0;
  logic [W-1:0]  trk = '0, exp_val = '0;
  logic [CW-1:0] min_cyc = '0, max_cyc = '0;
  logic [1:0]    mode = '0;
  logic [P-1:0]  alert_pipe, ack_pipe;
  logic          overflow;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  win_resp_mon #(.W(W), .P(P), .CW(CW)) i_win_resp_mon (
    .clk, .rst, .en, .trig, .trk, .exp_val, .min_cyc, .max_cyc, .mode,
    .alert_pipe, .ack_pipe, .overflow
  );

  typedef struct packed {
    logic [1:0]  md;
    logic [3:0]  mn;
    logic [3:0]  mx;
    logic [7:0]  ex;
    logic [63:0] sq;   // byte k = tracked value at cycle k
    logic        ok;   // 1 = pass expected, 0 = fail expected
    logic [3:0]  at;   // cycle of the deciding edge
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd1, 4'd3, 8'hA5, 64'hA5A5A5A5_A5A5A500, 1'b1, 4'd3},
    '{2'd0, 4'd1, 4'd3, 8'hA5, 64'h11111111_1111A500, 1'b0, 4'd2},
    '{2'd0, 4'd0, 4'd0, 8'hA5, 64'hA5A5A5A5_A5A5A5A5, 1'b1, 4'd0},
    '{2'd0, 4'd0, 4'd0, 8'hA5, 64'h00000000_00000000, 1'b0, 4'd0},
    '{2'd1, 4'd1, 4'd3, 8'hA5, 64'hA5A5A5A5_A5A51100, 1'b1, 4'd2},
    '{2'd1, 4'd1, 4'd3, 8'hA5, 64'hA5A5A5A5_A5A5A500, 1'b0, 4'd3},
    '{2'd1, 4'd0, 4'd2, 8'hA5, 64'h00000000_000000A5, 1'b0, 4'd2},
    '{2'd1, 4'd0, 4'd4, 8'hA5, 64'hA5A5A5A5_A5A500A5, 1'b1, 4'd2},
    '{2'd2, 4'd0, 4'd3, 8'hA5, 64'h07070707_07070505, 1'b1, 4'd2},
    '{2'd2, 4'd1, 4'd3, 8'hA5, 64'h02020202_02020201, 1'b0, 4'd3},
    '{2'd2, 4'd0, 4'd0, 8'hA5, 64'h66666666_66666666, 1'b0, 4'd0},
    '{2'd3, 4'd1, 4'd4, 8'hA5, 64'h33333333_33333300, 1'b1, 4'd4},
    '{2'd3, 4'd1, 4'd4, 8'hA5, 64'h34343434_34333300, 1'b0, 4'd3},
    '{2'd3, 4'd0, 4'd0, 8'hA5, 64'h77777777_77777777, 1'b1, 4'd0}
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit good, input string tag, input int act, input int expv);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic setup(input logic [1:0] md, input int mn, input int mx, input logic [7:0] ex);
    en = 1'b0; trig = 1'b0;
    step();
    mode = md; min_cyc = CW'(mn); max_cyc = CW'(mx); exp_val = ex;
    en = 1'b1;
    step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk(alert_pipe == 0 && ack_pipe == 0 && !overflow, "R1 in reset",
        {alert_pipe, ack_pipe, overflow}, 0);
    rst = 1'b0;
    step();
    chk(alert_pipe == 0 && ack_pipe == 0 && !overflow, "R1 after reset",
        {alert_pipe, ack_pipe, overflow}, 0);

    // vector table: one window per vector on tracker 0 (R2..R6)
    for (int v = 0; v < NV; v++) begin
      int got_at;
      bit got_ok, dual;
      string tag;
      got_at = 15; got_ok = 0; dual = 0;
      setup(VECS[v].md, int'(VECS[v].mn), int'(VECS[v].mx), VECS[v].ex);
      for (int k = 0; k < 8; k++) begin
        trig = (k == 0);
        trk  = VECS[v].sq[k*8 +: 8];
        step();
        if ((alert_pipe[0] & ack_pipe[0]) == 1'b1) dual = 1;
        if (got_at == 15 && (alert_pipe != 0 || ack_pipe != 0)) begin
          got_at = k;
          got_ok = ack_pipe[0];
        end
      end
      case (VECS[v].md)
        2'd0: tag = "R3 value mode";
        2'd1: tag = "R4 change-to-value mode";
        2'd2: tag = "R5 change mode";
        default: tag = "R6 stable mode";
      endcase
      chk(got_ok == VECS[v].ok, {tag, " outcome"}, got_ok, VECS[v].ok);
      chk(got_at == int'(VECS[v].at), {tag, " R2 cycle"}, got_at, VECS[v].at);
      chk(!dual, "R11 dual report", dual, 0);
    end

    // R8: overlapping windows on consecutive edges, value mode 2..2
    setup(2'd0, 2, 2, 8'hA5);
    trig = 1'b1; trk = 8'h00; step();
    step();
    trig = 1'b0; trk = 8'hA5; step();
    chk(ack_pipe == 4'b0001 && alert_pipe == 0, "R8 pipe0 pass", {ack_pipe, alert_pipe}, 8'h10);
    trk = 8'h00; step();
    chk(alert_pipe == 4'b0010 && ack_pipe == 0, "R8 pipe1 fail", {ack_pipe, alert_pipe}, 8'h02);

    // R9 / R7: fill all trackers, then reuse the first one freed
    setup(2'd0, 5, 5, 8'hA5);
    trk = 8'hA5; trig = 1'b1;
    repeat (4) step();
    chk(!overflow, "R9 no overflow while free", overflow, 0);
    step();
    chk(overflow, "R9 overflow when full", overflow, 1);
    trig = 1'b0; step();
    chk(ack_pipe == 4'b0001 && !overflow, "R9 first window pass", {ack_pipe, overflow}, 5'h02);
    trig = 1'b1; step();
    chk(ack_pipe == 4'b0010 && !overflow, "R7 freed tracker taken", {ack_pipe, overflow}, 5'h04);
    trig = 1'b0;
    repeat (5) step();
    chk(ack_pipe == 4'b0001, "R7 reused tracker 0 pass", ack_pipe, 1);

    // R10: enable drop discards an open window
    setup(2'd0, 2, 2, 8'hA5);
    trk = 8'h00; trig = 1'b1; step();
    trig = 1'b0; en = 1'b0; step();
    en = 1'b1; step();
    chk(alert_pipe == 0 && ack_pipe == 0, "R10 no pulse after disable", {alert_pipe, ack_pipe}, 0);
    step();
    chk(alert_pipe == 0 && ack_pipe == 0, "R10 still quiet", {alert_pipe, ack_pipe}, 0);

    // R10: configuration latched at enable rise
    setup(2'd0, 0, 0, 8'hA5);
    exp_val = 8'h00; min_cyc = 8'd3; max_cyc = 8'd3;
    trk = 8'hA5; trig = 1'b1; step();
    trig = 1'b0;
    chk(ack_pipe == 4'b0001 && alert_pipe == 0, "R10 latched config used", {ack_pipe, alert_pipe}, 8'h10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule